// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block keeps the status register of a 128K x 8 serial nonvolatile memory and decides whether each write to the array or to the status register may go ahead. It receives command strobes that are already decoded: write-enable, write-disable, status write with a data byte, and array write with a 17-bit address. It also receives the level of the external write-protect pin. The block answers each write with a one-cycle grant or reject pulse. It presents the status byte that a read-status command returns.

It contains the timer for the internal write cycle. An accepted write starts a timed busy period. During that period the status byte reads as all ones and every further write is refused. New protection settings take effect only when the period ends. A two-bit level protects the top quarter, the top half or the whole array. A lock bit, combined with a low protect pin, freezes the status register.

Top module: `memprot_ctrl`

## Requirements
- R1: After reset the status byte is 8'h00. When not busy, the byte is `{lock, 3'b000, lvl[1], lvl[0], wel, 1'b0}`: bit 0 busy, bit 1 write-enable latch, bits 3:2 protection level, bits 6:4 zero, bit 7 lock.
- R2: While a write cycle runs, the status byte reads 8'hFF.
- R3: An array write is rejected when its address lies in the protected range. Level 0 protects nothing. Level 1 protects 0x18000..0x1FFFF. Level 2 protects 0x10000..0x1FFFF. Level 3 protects 0x00000..0x1FFFF.
- R4: Hardware lock is active when `wp_n` is low and the lock bit is 1. While it is active, status writes are rejected and the level and lock bits do not change. Array writes outside the protected range are still granted.
- R5: A write is rejected when the write-enable latch is 0 or a write cycle is running. A rejected write changes no state, and the latch stays as it was.
- R6: An accepted write keeps `busy` high for exactly WR_CYCLES cycles. At the end of that period a status write's bits 2, 3 and 7 take effect and the write-enable latch clears. The other data bits are ignored.
- R7: The write-enable strobe sets the latch and the write-disable strobe clears it. Both are ignored while busy.
- R8: `grant` or `reject` pulses high for one cycle, in the cycle after the write strobe's clock edge, and the two are never high together.
- R9: When strobes coincide, only one acts. The priority is array write, then status write, then write-disable, then write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_cmd | input | 1 | Write-enable strobe |
| wrdi_cmd | input | 1 | Write-disable strobe |
| wrsr_cmd | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Status write data byte |
| wr_cmd | input | 1 | Array write strobe |
| wr_addr | input | 17 | Array write byte address |
| wp_n | input | 1 | Write-protect pin level, low asserts |
| status_q | output | 8 | Status byte for read-status |
| grant | output | 1 | Write accepted pulse |
| reject | output | 1 | Write refused pulse |
| busy | output | 1 | Write cycle in progress |

## Verification
A strobe presented before clock edge E produces `grant` or `reject` in the cycle after E. If the strobe is accepted, `busy` and the 8'hFF status byte also appear in that same cycle. The new level and lock bits, and the cleared latch, appear WR_CYCLES cycles later, in the first cycle where `busy` is low. The bench drives strobes on the falling edge and samples at the next falling edge. It then counts falling edges while `busy` is high, so every comparison lands exactly on the cycle where the requirement places the result.

// File: rtl/memprot_pkg.sv
package memprot_pkg;

   typedef enum logic [1:0] {
      LVL_NONE    = 2'd0,
      LVL_QUARTER = 2'd1,
      LVL_HALF    = 2'd2,
      LVL_ALL     = 2'd3
   } prot_lvl_e;

   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_SETWE = 3'd1,
      OP_CLRWE = 3'd2,
      OP_STWR  = 3'd3,
      OP_ARWR  = 3'd4
   } op_e;

   localparam int ST_BUSY_BIT = 0;
   localparam int ST_WEL_BIT  = 1;
   localparam int ST_LVL_LO   = 2;
   localparam int ST_LVL_HI   = 3;
   localparam int ST_LOCK_BIT = 7;

   // The level selects how many top quarters of the array are covered
   function automatic logic lvl_covers(input prot_lvl_e lvl, input logic [1:0] quarter);
      case (lvl)
         LVL_NONE:    return 1'b0;
         LVL_QUARTER: return (quarter == 2'b11);
         LVL_HALF:    return quarter[1];
         default:     return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/memprot_range.sv
module memprot_range
   import memprot_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  prot_lvl_e          lvl,
   input  logic [ADDR_W-1:0]  addr,
   output logic               hit
);
   localparam int NUM_LVL = 4;

   if (ADDR_W < 2) begin : g_bad_width
      $error("memprot_range: ADDR_W must be at least 2");
   end

   logic [1:0]         quarter;
   logic [NUM_LVL-1:0] hit_vec;

   assign quarter = addr[ADDR_W-1 -: 2];

   for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
      assign hit_vec[k] = lvl_covers(prot_lvl_e'(k), quarter);
   end

   assign hit = hit_vec[lvl];

endmodule

// File: rtl/memprot_timer.sv
module memprot_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CNT_W = $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("memprot_timer: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/memprot_status.sv
module memprot_status
   import memprot_pkg::*;
#(
   parameter logic [1:0] DEF_LVL  = 2'b00,
   parameter logic       DEF_LOCK = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      set_wel,
   input  logic      clr_wel,
   input  logic      stage,
   input  prot_lvl_e stage_lvl,
   input  logic      stage_lock,
   input  logic      commit,
   output prot_lvl_e lvl,
   output logic      lock,
   output logic      wel
);
   prot_lvl_e lvl_q, pend_lvl_q;
   logic      lock_q, pend_lock_q, pend_q, wel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q <= 1'b0;
      end else if (commit || clr_wel) begin
         wel_q <= 1'b0;
      end else if (set_wel) begin
         wel_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_lvl_q  <= prot_lvl_e'(DEF_LVL);
         pend_lock_q <= DEF_LOCK;
      end else if (stage) begin
         pend_q      <= 1'b1;
         pend_lvl_q  <= stage_lvl;
         pend_lock_q <= stage_lock;
      end else if (commit) begin
         pend_q      <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= prot_lvl_e'(DEF_LVL);
         lock_q <= DEF_LOCK;
      end else if (commit && pend_q) begin
         lvl_q  <= pend_lvl_q;
         lock_q <= pend_lock_q;
      end
   end

   assign lvl  = lvl_q;
   assign lock = lock_q;
   assign wel  = wel_q;

endmodule

// File: rtl/memprot_ctrl.sv
module memprot_ctrl
   import memprot_pkg::*;
#(
   parameter int         ADDR_W    = 17,
   parameter int         WR_CYCLES = 16,
   parameter logic [1:0] DEF_LVL   = 2'b00,
   parameter logic       DEF_LOCK  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wren_cmd,
   input  logic              wrdi_cmd,
   input  logic              wrsr_cmd,
   input  logic [7:0]        wrsr_data,
   input  logic              wr_cmd,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wp_n,
   output logic [7:0]        status_q,
   output logic              grant,
   output logic              reject,
   output logic              busy
);
   localparam logic [7:0] BUSY_BYTE = 8'hFF;

   op_e       op;
   prot_lvl_e lvl;
   logic      lock, wel, hit, hw_lock, may_write;
   logic      acc_arr, acc_sr, rej, done, busy_int;
   logic      grant_q, reject_q;
   logic      unused_sr_bits;

   assign unused_sr_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};

   // Priority among coincident strobes
   always_comb begin
      if (wr_cmd)        op = OP_ARWR;
      else if (wrsr_cmd) op = OP_STWR;
      else if (wrdi_cmd) op = OP_CLRWE;
      else if (wren_cmd) op = OP_SETWE;
      else               op = OP_IDLE;
   end

   memprot_range #(.ADDR_W(ADDR_W)) u_range (
      .lvl  (lvl),
      .addr (wr_addr),
      .hit  (hit)
   );

   assign hw_lock   = ~wp_n & lock;
   assign may_write = wel & ~busy_int;
   assign acc_arr   = (op == OP_ARWR) && may_write && !hit;
   assign acc_sr    = (op == OP_STWR) && may_write && !hw_lock;
   assign rej       = ((op == OP_ARWR) && !acc_arr) || ((op == OP_STWR) && !acc_sr);

   memprot_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (acc_arr | acc_sr),
      .busy  (busy_int),
      .done  (done)
   );

   memprot_status #(.DEF_LVL(DEF_LVL), .DEF_LOCK(DEF_LOCK)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_wel    ((op == OP_SETWE) && !busy_int),
      .clr_wel    ((op == OP_CLRWE) && !busy_int),
      .stage      (acc_sr),
      .stage_lvl  (prot_lvl_e'({wrsr_data[ST_LVL_HI], wrsr_data[ST_LVL_LO]})),
      .stage_lock (wrsr_data[ST_LOCK_BIT]),
      .commit     (done),
      .lvl        (lvl),
      .lock       (lock),
      .wel        (wel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q  <= 1'b0;
         reject_q <= 1'b0;
      end else begin
         grant_q  <= acc_arr | acc_sr;
         reject_q <= rej;
      end
   end

   always_comb begin
      if (busy_int) begin
         status_q = BUSY_BYTE;
      end else begin
         status_q = '0;
         status_q[ST_BUSY_BIT] = 1'b0;
         status_q[ST_WEL_BIT]  = wel;
         status_q[ST_LVL_LO]   = lvl[0];
         status_q[ST_LVL_HI]   = lvl[1];
         status_q[ST_LOCK_BIT] = lock;
      end
   end

   assign grant  = grant_q;
   assign reject = reject_q;
   assign busy   = busy_int;

endmodule

// File: rtl/memprot_chk.sv
module memprot_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wrsr_cmd,
   input logic              wr_cmd,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wp_n,
   input logic [7:0]        status_q,
   input logic              grant,
   input logic              reject,
   input logic              busy
);
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (status_q[6:4] == 3'b000 && !status_q[0]));                        // R1
   AST_BUSY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (status_q == 8'hFF));                                               // R2
   AST_PROT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && !busy && status_q[3:2] == 2'b11) |=> (reject && !grant));         // R3
   AST_PROT_QTR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && !busy && status_q[3:2] == 2'b01 && wr_addr[ADDR_W-1 -: 2] == 2'b11)
      |=> (reject && !grant));                                                     // R3
   AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (wrsr_cmd && !wr_cmd && !busy && !wp_n && status_q[7]) |=> reject);          // R4
   AST_NEED_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && !busy && !status_q[1]) |=> (reject && !grant));                   // R5
   AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (wr_cmd || wrsr_cmd)) |=> (reject && !grant));                      // R5
   AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> busy);                                                             // R6
   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && reject));                                                         // R8
endmodule

bind memprot_ctrl memprot_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wrsr_cmd (wrsr_cmd),
   .wr_cmd   (wr_cmd),
   .wr_addr  (wr_addr),
   .wp_n     (wp_n),
   .status_q (status_q),
   .grant    (grant),
   .reject   (reject),
   .busy     (busy)
);

// File: tb/tb_memprot_ctrl.sv
module tb_memprot_ctrl;
   localparam int AW  = 17;
   localparam int CYC = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wren_cmd = 0, wrdi_cmd = 0, wrsr_cmd = 0, wr_cmd = 0, wp_n = 1;
   logic [7:0] wrsr_data = '0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0] status_q;
   logic grant, reject, busy;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   memprot_ctrl #(.ADDR_W(AW), .WR_CYCLES(CYC)) dut (
      .clk(clk), .rst_n(rst_n), .wren_cmd(wren_cmd), .wrdi_cmd(wrdi_cmd),
      .wrsr_cmd(wrsr_cmd), .wrsr_data(wrsr_data), .wr_cmd(wr_cmd),
      .wr_addr(wr_addr), .wp_n(wp_n), .status_q(status_q), .grant(grant),
      .reject(reject), .busy(busy)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic cmd_wren();
      @(negedge clk) wren_cmd = 1;
      @(negedge clk) wren_cmd = 0;
   endtask

   task automatic cmd_wrdi();
      @(negedge clk) wrdi_cmd = 1;
      @(negedge clk) wrdi_cmd = 0;
   endtask

   task automatic cmd_wrsr(input logic [7:0] d, output logic g, output logic r);
      @(negedge clk) begin wrsr_cmd = 1; wrsr_data = d; end
      @(negedge clk) begin g = grant; r = reject; wrsr_cmd = 0; end
   endtask

   task automatic cmd_wr(input logic [AW-1:0] a, output logic g, output logic r);
      @(negedge clk) begin wr_cmd = 1; wr_addr = a; end
      @(negedge clk) begin g = grant; r = reject; wr_cmd = 0; end
   endtask

   // Counts busy cycles from the current negedge; checks FF readout (R2)
   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin
         n++;
         check(status_q == 8'hFF, "R2 busy readout", status_q, 8'hFF);
         @(negedge clk);
      end
   endtask

   task automatic set_status(input logic [7:0] d);
      logic g, r;
      int n;
      cmd_wren();
      cmd_wrsr(d, g, r);
      check(g && !r, "R6 status write granted", {g, r}, 2'b10);
      wait_idle(n);
      check(n == CYC, "R6 busy length", n, CYC);
      check(status_q == {d[7], 3'b000, d[3:2], 2'b00}, "R6 committed status",
            status_q, {d[7], 3'b000, d[3:2], 2'b00});
   endtask

   function automatic logic in_range(input int lvl, input int a);
      case (lvl)
         0: return 1'b0;
         1: return a >= 'h18000;
         2: return a >= 'h10000;
         default: return 1'b1;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic g, r;
      int n;
      int addrs[$];
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(status_q == 8'h00, "R1 reset status", status_q, 0);
      check(!busy && !grant && !reject, "R1 reset outputs", {busy, grant, reject}, 0);

      // R5: write without latch
      cmd_wr('h00100, g, r);
      check(!g && r, "R5 write without latch", {g, r}, 2'b01);
      @(negedge clk);
      check(!reject, "R8 reject is one cycle", reject, 0);
      check(status_q == 8'h00, "R5 no state change", status_q, 0);

      // R7 latch set and cleared
      cmd_wren();
      check(status_q == 8'h02, "R7 latch set", status_q, 8'h02);
      cmd_wrdi();
      check(status_q == 8'h00, "R7 latch cleared", status_q, 0);

      // R9: coincident enable and disable -> disable wins
      cmd_wren();
      @(negedge clk) begin wren_cmd = 1; wrdi_cmd = 1; end
      @(negedge clk) begin wren_cmd = 0; wrdi_cmd = 0; end
      check(status_q == 8'h00, "R9 disable beats enable", status_q, 0);

      // R6: ignored data bits, latch cleared at end
      set_status(8'h73);
      check(status_q == 8'h00, "R6 ignored data bits", status_q, 0);

      // R3 sweep over levels and addresses
      for (int a = 0; a < (1 << AW); a += 'h1000) addrs.push_back(a);
      addrs.push_back('h17FFF); addrs.push_back('h0FFFF); addrs.push_back('h1FFFF);
      for (int lvl = 0; lvl < 4; lvl++) begin
         set_status(8'(lvl << 2));
         foreach (addrs[i]) begin
            logic exp_g;
            exp_g = !in_range(lvl, addrs[i]);
            cmd_wren();
            cmd_wr(AW'(addrs[i]), g, r);
            check(g == exp_g && r == !exp_g, $sformatf("R3 lvl%0d addr %0h", lvl, addrs[i]),
                  {g, r}, {exp_g, !exp_g});
            if (g) begin
               wait_idle(n);
               check(n == CYC, "R6 array busy length", n, CYC);
               check(status_q[1] == 1'b0, "R6 latch cleared after write", status_q, 0);
            end else begin
               check(status_q[1] == 1'b1, "R5 latch kept after refusal", status_q, 2);
               cmd_wrdi();
            end
         end
      end

      // R5 / R7 during busy
      set_status(8'h00);
      cmd_wren();
      cmd_wr('h00000, g, r);
      check(g, "R5 setup write", g, 1);
      cmd_wrsr(8'h0C, g, r);
      check(!g && r, "R5 refused while busy", {g, r}, 2'b01);
      cmd_wren();
      wait_idle(n);
      check(status_q == 8'h00, "R7 enable ignored while busy", status_q, 0);

      // R9: array write beats status write
      cmd_wren();
      @(negedge clk) begin wr_cmd = 1; wr_addr = 'h00010; wrsr_cmd = 1; wrsr_data = 8'h0C; end
      @(negedge clk) begin g = grant; wr_cmd = 0; wrsr_cmd = 0; end
      check(g, "R9 array write granted", g, 1);
      wait_idle(n);
      check(status_q == 8'h00, "R9 status write dropped", status_q, 0);

      // R4 hardware lock
      set_status(8'h80);
      wp_n = 0;
      cmd_wren();
      cmd_wrsr(8'h00, g, r);
      check(!g && r, "R4 status write locked", {g, r}, 2'b01);
      @(negedge clk);
      check(status_q == 8'h82, "R4 lock kept", status_q, 8'h82);
      cmd_wr('h1FFFF, g, r);
      check(g && !r, "R4 array write still allowed", {g, r}, 2'b10);
      wait_idle(n);
      wp_n = 1;
      set_status(8'h00);
      check(status_q == 8'h00, "R4 unlocked with pin high", status_q, 0);

      finish_run();
   end
endmodule